// File: doc/BRIEF.md
# Edge-Triggered Interrupt Controller

This block gathers fifteen interrupt sources: ten general-purpose IO pins, two clip-detect flags, a converter-ready flag and two touch-panel low flags. For each source it records a rising transition, a falling transition, or both, in a sticky status bit. Each source has its own bit in a rising-edge enable word and its own bit in a falling-edge enable word. A single request output is the OR of all status bits. Software reads the status word, and it clears a status bit by writing a one and then a zero to that bit position.

The status latches are clocked by the source signals themselves, not by the register clock. An edge that arrives while the register clock is stopped, for example in power-down, still sets status and raises the request. The same register port also holds a direction bit and an output bit for each IO pin, and a read of the pin word returns the level on the pins.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After reset, every register reads zero: pin direction, pin output, rising enable, falling enable and status. The request output is low, and the pin output and output-enable buses are zero.
- R2: With its rising-enable bit set, a 0-to-1 change on a source sets that source's status bit. The status bit positions are: IO pins 0..9 in bits 0..9, audio clip in bit 10, telecom clip in bit 11, converter ready in bit 12, touch plus-low in bit 13, touch minus-low in bit 14.
- R3: With its falling-enable bit set, a 1-to-0 change on a source sets that source's status bit. A 0-to-1 change with only the falling enable set leaves the bit clear.
- R4: A change on a source whose rising and falling enable bits are both zero never sets its status bit.
- R5: With both enable bits set, either direction of change sets the status bit.
- R6: A status bit stays set after the source returns to its former level.
- R7: A write to the status address with bit x at 0 clears status bit x only if the previous status write held bit x at 1. A write of 0 after a previous 0 clears nothing. A write of 1 clears nothing and sets nothing. Other bits are unaffected.
- R8: The request output is high exactly while any status bit is set. It responds to source edges combinationally, with the register clock stopped.
- R9: The status word reaches the read data through two register-clock stages. A new status is not visible one clock after it is captured, and it is visible after the second clock.
- R10: The direction bits drive the per-pin output-enable bus, and the output bits drive the pin output bus. A read of the pin word returns the pin input levels through two clock stages, not the written output value.
- R11: Register addresses are: 0 pin levels (write sets the pin outputs), 1 direction, 2 rising enable, 3 falling enable, 4 status. Register bits beyond a register's width read 0, and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 15 | Write data |
| reg_rdata | output | 15 | Read data for the addressed register |
| pin_level_i | input | 10 | Levels on the IO pins, also interrupt sources 0..9 |
| pin_out_o | output | 10 | Pin output values |
| pin_oe_o | output | 10 | Pin output enables (1 = drive) |
| aux_src_i | input | 5 | Clip, converter-ready and touch-low flags (sources 10..14) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives source changes under each enable setting: rising only, falling only, both, and none. These patterns show whether the enable word gates the correct edge direction. Clear sequences of zero-only, one-only and one-then-zero show that only the written 1-to-0 transition clears a bit, and that other bits are not affected. A single event timed against the clock edges checks the two-stage read latency. A run with the clock held stopped shows that capture and the request output do not depend on the clock.

// File: rtl/irq_edge_pkg.sv
// Package: shared sizes and the register address map of the edge interrupt block.
// Assumes the source count fits in one register word (the word is as wide as the source count).
package irq_edge_pkg;
    localparam int NUM_IO  = 10;
    localparam int NUM_AUX = 5;
    localparam int NUM_SRC = NUM_IO + NUM_AUX;
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PIN  = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_RISE = 3'd2,
        SEL_FALL = 3'd3,
        SEL_STAT = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/irq_edge_cell.sv
// Module: one source's edge catcher. Two flops clocked by the source itself,
// one on each edge, each setting only when its enable is high.
// Assumes kill_i is a glitch-free, register-driven level; while it is high both flops are held clear.
module irq_edge_cell (
    input  logic src_i,
    input  logic rise_en_i,
    input  logic fall_en_i,
    input  logic kill_i,
    output logic stat_o
);
    logic up_q;
    logic dn_q;

    // Capture a rising transition when enabled.
    always_ff @(posedge src_i or posedge kill_i) begin
        if (kill_i)         up_q <= 1'b0;
        else if (rise_en_i) up_q <= 1'b1;
    end

    // Capture a falling transition when enabled.
    always_ff @(negedge src_i or posedge kill_i) begin
        if (kill_i)         dn_q <= 1'b0;
        else if (fall_en_i) dn_q <= 1'b1;
    end

    // Status is set by either capture.
    assign stat_o = up_q | dn_q;
endmodule

// File: rtl/irq_sync2.sv
// Module: two-stage synchronizer that brings a bus of asynchronous levels into the clock domain.
// Assumes each bit is treated on its own; no multi-bit coherence is promised.
module irq_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [1:0]   age_q;

    // Shift the asynchronous value through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end

    // Count cycles since reset (for the checker only), saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R9
    sync_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && d_i == $past(d_i) && d_i == $past(d_i, 2)) |-> q_o == d_i);
endmodule

// File: rtl/irq_clear_gen.sv
// Module: forms per-bit clear pulses from writes to the status address.
// A bit clears when it is written as 0 and the previous status write had it at 1.
// Assumes the pulse is registered so the latch reset it drives is glitch-free.
module irq_clear_gen #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] clr_o
);
    logic [N-1:0] shadow_q;

    // Remember the last value written to the status address.
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow_q <= '0;
        else if (wr_i) shadow_q <= wdata_i;
    end

    // Raise a one-cycle clear on each written 1-to-0 transition.
    always_ff @(posedge clk) begin
        if (!rst_n)    clr_o <= '0;
        else if (wr_i) clr_o <= shadow_q & ~wdata_i;
        else           clr_o <= '0;
    end

    // R7
    clr_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o != '0) |-> $past(wr_i));

    // R7
    clr_needs_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o != '0) |-> (($past(shadow_q) & clr_o) == clr_o));
endmodule

// File: rtl/irq_edge_ctrl.sv
// Module: edge-triggered interrupt controller with pin direction/output registers.
// Source edges are caught by clockless latches; register access, clears and the
// status read path run on clk. Global reset reaches the latches through a registered
// level, so the latch reset is glitch-free and comes from one clock domain.
module irq_edge_ctrl
    import irq_edge_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    input  logic [NUM_IO-1:0]  pin_level_i,
    output logic [NUM_IO-1:0]  pin_out_o,
    output logic [NUM_IO-1:0]  pin_oe_o,
    input  logic [NUM_AUX-1:0] aux_src_i,
    output logic               irq_o
);
    logic [NUM_IO-1:0]  out_q;
    logic [NUM_IO-1:0]  dir_q;
    logic [NUM_SRC-1:0] rise_q;
    logic [NUM_SRC-1:0] fall_q;
    logic               rst_hold_q;
    logic [NUM_SRC-1:0] clr_w;
    logic [NUM_SRC-1:0] src_w;
    logic [NUM_SRC-1:0] stat_raw;
    logic [NUM_SRC-1:0] stat_sync;
    logic [NUM_IO-1:0]  pin_sync;
    logic               stat_wr;

    assign src_w   = {aux_src_i, pin_level_i};
    assign stat_wr = reg_wr && (reg_addr == SEL_STAT);

    // Hold a registered copy of reset for the clockless latches.
    always_ff @(posedge clk) begin
        rst_hold_q <= !rst_n;
    end

    // Store the pin output, direction and edge-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                SEL_PIN:  out_q  <= reg_wdata[NUM_IO-1:0];
                SEL_DIR:  dir_q  <= reg_wdata[NUM_IO-1:0];
                SEL_RISE: rise_q <= reg_wdata;
                SEL_FALL: fall_q <= reg_wdata;
                default:  ;
            endcase
        end
    end

    irq_clear_gen #(.N(NUM_SRC)) u_clear (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (stat_wr),
        .wdata_i (reg_wdata),
        .clr_o   (clr_w)
    );

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_cell
        irq_edge_cell u_cell (
            .src_i     (src_w[gi]),
            .rise_en_i (rise_q[gi]),
            .fall_en_i (fall_q[gi]),
            .kill_i    (rst_hold_q | clr_w[gi]),
            .stat_o    (stat_raw[gi])
        );
    end

    irq_sync2 #(.W(NUM_SRC)) u_stat_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (stat_raw),
        .q_o   (stat_sync)
    );

    irq_sync2 #(.W(NUM_IO)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_level_i),
        .q_o   (pin_sync)
    );

    // Select the read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_PIN:  reg_rdata[NUM_IO-1:0] = pin_sync;
            SEL_DIR:  reg_rdata[NUM_IO-1:0] = dir_q;
            SEL_RISE: reg_rdata = rise_q;
            SEL_FALL: reg_rdata = fall_q;
            SEL_STAT: reg_rdata = stat_sync;
            default:  reg_rdata = '0;
        endcase
    end

    assign pin_out_o = out_q;
    assign pin_oe_o  = dir_q;
    assign irq_o     = |stat_raw;

    // R1
    always @(negedge clk) begin
        if (rst_hold_q) reset_quiet_chk: assert (!irq_o);
    end

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !$past(irq_o)) |-> ((rise_q | fall_q | $past(rise_q) | $past(fall_q)) != '0));

    // R4
    set_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_raw & ~$past(stat_raw)) & ~(rise_q | fall_q | $past(rise_q) | $past(fall_q))) == '0);
endmodule

// File: tb/sim_irq_edge_ctrl.sv
module sim_irq_edge_ctrl;
    import irq_edge_pkg::*;

    logic clk_raw = 1'b0;
    logic clk_run = 1'b1;
    logic clk;
    assign clk = clk_raw & clk_run;
    always #4 clk_raw = ~clk_raw;

    logic               rst_n = 1'b0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic               reg_wr = 1'b0;
    logic [NUM_SRC-1:0] reg_wdata = '0;
    logic [NUM_SRC-1:0] reg_rdata;
    logic [NUM_IO-1:0]  pin_level = '0;
    logic [NUM_IO-1:0]  pin_out;
    logic [NUM_IO-1:0]  pin_oe;
    logic [NUM_AUX-1:0] aux = '0;
    logic               irq;

    irq_edge_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_level_i(pin_level),
        .pin_out_o(pin_out), .pin_oe_o(pin_oe), .aux_src_i(aux), .irq_o(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [NUM_SRC-1:0] exp;
        string              tag;
    } item_t;
    item_t sb_q[$];
    logic  rd_req = 1'b0;

    // Monitor: pop the expected read and compare with the design's read data.
    always @(negedge clk) begin
        item_t it;
        if (rd_req) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: got %h expected none", reg_rdata);
            end else begin
                it = sb_q.pop_front();
                if (reg_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", it.tag, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [NUM_SRC-1:0] act, input logic [NUM_SRC-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [NUM_SRC-1:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [NUM_SRC-1:0] exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        reg_addr = a;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        rd_req = 1'b1;
        @(posedge clk); #1;
        rd_req = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic clear_bits(input logic [NUM_SRC-1:0] m);
        wr(3'd4, m);
        wr(3'd4, '0);
        settle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1600000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();

        // R1: reset state
        chk("R1 irq", {14'd0, irq}, '0);
        chk("R1 oe", {5'd0, pin_oe}, '0);
        chk("R1 out", {5'd0, pin_out}, '0);
        rd(3'd0, '0, "R1 pin");
        rd(3'd1, '0, "R1 dir");
        rd(3'd2, '0, "R1 rise");
        rd(3'd3, '0, "R1 fall");
        rd(3'd4, '0, "R1 status");

        // R10 / R11: pin registers and map
        wr(3'd1, 15'h7FFF);
        wr(3'd0, 15'h02A5);
        @(negedge clk);
        chk("R10 oe", {5'd0, pin_oe}, 15'h03FF);
        chk("R10 out", {5'd0, pin_out}, 15'h02A5);
        rd(3'd1, 15'h03FF, "R11 dir width");
        rd(3'd5, '0, "R11 unused address");
        rd(3'd7, '0, "R11 unused address 7");
        @(posedge clk); #1 pin_level = 10'h155;
        settle();
        rd(3'd0, 15'h0155, "R10 pin level read");

        // R4: changes with no enables
        rd(3'd4, '0, "R4 pins no enable");
        aux = 5'h1F; settle(); aux = 5'h00; settle();
        rd(3'd4, '0, "R4 aux no enable");
        chk("R4 irq", {14'd0, irq}, '0);
        pin_level = '0; settle();

        // R2: rising capture on pin 0 and converter-ready (bit 12)
        wr(3'd2, 15'h1001);
        rd(3'd2, 15'h1001, "R11 rise readback");
        pin_level[0] = 1'b1; #1;
        chk("R8 irq on rise", {14'd0, irq}, 15'd1);
        settle();
        rd(3'd4, 15'h0001, "R2 pin0");
        aux[2] = 1'b1; settle();
        rd(3'd4, 15'h1001, "R2 ready flag");

        // R6: sticky
        pin_level[0] = 1'b0; aux[2] = 1'b0; settle();
        rd(3'd4, 15'h1001, "R6 sticky");

        // R7: clear semantics
        wr(3'd4, 15'h0000); settle();
        rd(3'd4, 15'h1001, "R7 zero after zero");
        wr(3'd4, 15'h0001); settle();
        rd(3'd4, 15'h1001, "R7 one only");
        wr(3'd4, 15'h0000); settle();
        rd(3'd4, 15'h1000, "R7 one-to-zero clears bit0 only");
        chk("R8 irq still set", {14'd0, irq}, 15'd1);
        clear_bits(15'h1000);
        rd(3'd4, '0, "R7 cleared");
        chk("R8 irq low", {14'd0, irq}, '0);
        wr(3'd4, 15'h7FFF); settle();
        rd(3'd4, '0, "R7 write does not set");
        wr(3'd4, 15'h0000); settle();

        // R3: falling capture on touch plus-low (bit 13)
        wr(3'd3, 15'h2000);
        aux[3] = 1'b1; settle();
        rd(3'd4, '0, "R3 rise ignored");
        aux[3] = 1'b0; settle();
        rd(3'd4, 15'h2000, "R3 fall");
        clear_bits(15'h2000);

        // R5: both edges on pin 5
        wr(3'd2, 15'h0020);
        wr(3'd3, 15'h0020);
        pin_level[5] = 1'b1; settle();
        rd(3'd4, 15'h0020, "R5 rise");
        clear_bits(15'h0020);
        rd(3'd4, '0, "R5 cleared");
        pin_level[5] = 1'b0; settle();
        rd(3'd4, 15'h0020, "R5 fall");
        clear_bits(15'h0020);

        // R9: two-stage read latency on minus-low (bit 14)
        wr(3'd2, 15'h4000);
        wr(3'd3, 15'h0000);
        reg_addr = 3'd4;
        @(posedge clk); #1 aux[4] = 1'b1;
        #1 chk("R8 irq immediate", {14'd0, irq}, 15'd1);
        @(negedge clk);
        chk("R9 before capture", reg_rdata, '0);
        @(negedge clk);
        chk("R9 one stage", reg_rdata, '0);
        @(negedge clk);
        chk("R9 two stages", reg_rdata, 15'h4000);
        aux[4] = 1'b0;
        clear_bits(15'h4000);

        // R8: capture with the clock stopped
        wr(3'd2, 15'h0080);
        @(negedge clk_raw); clk_run = 1'b0;
        #20 pin_level[7] = 1'b1;
        #20 chk("R8 stopped clock irq", {14'd0, irq}, 15'd1);
        @(negedge clk_raw); clk_run = 1'b1;
        settle();
        rd(3'd4, 15'h0080, "R8 stopped clock status");

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule